// File: doc/BRIEF.md
# Extended DMA Descriptor Commit Front End

This block is the write-side front end of a scatter-gather DMA engine. Software writes the eight 32-bit words of an extended descriptor through a small word-addressed write port. Seven of the words (source and destination address halves, byte count, burst and sequence word, stride word) go into staging registers. Writing the control word with its go bit set commits all eight words together into a descriptor FIFO. The staged words are the values held before that cycle, and the control word is the value being written. Because the commit is a single action, the transfer engine never sees a descriptor that is only partly written.

The transfer engine takes descriptors from the FIFO through a valid/ready handshake. The whole 256-bit descriptor is presented at once. The block also decodes the burst, sequence, stride and control fields of the head entry, so the engine does not have to unpack them. Software can see the FIFO fill level and the full and empty flags, and it waits while the full flag is set. If a go write arrives while the FIFO is full, the descriptor is discarded and a sticky overflow flag is raised.

Top module: `xdesc_commit`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the outputs are as follows: `fifo_empty`=1, `fifo_full`=0, `fill_level`=0, `overflow`=0 and `q_valid`=0.
- R2: A write to word index 0..6, or to index 7 with bit 31 clear, commits nothing. `fill_level` does not change.
- R3: A write to index 7 with bit 31 set, while the FIFO is not full, commits a descriptor. In the next cycle `fill_level` is one higher and `q_valid` is 1. Word k of the entry sits in `q_desc[32k+31:32k]`. Words 0..6 are the staged values and word 7 is the written data.
- R4: Staging registers keep their contents after a commit. A second go write with no other writes commits the same words 0..6 again.
- R5: Entries leave in commit order. A cycle with `q_valid` and `q_ready` both high removes the head entry and lowers `fill_level` by one.
- R6: `fifo_full` is 1 exactly when `fill_level` equals DEPTH. `fifo_empty` is 1 exactly when `fill_level` is 0.
- R7: A go write while `fifo_full` is 1 is discarded and leaves the FIFO contents and level unchanged. It sets `overflow`, which stays 1 until reset.
- R8: A go write and a pop in the same cycle, with the FIFO neither full nor empty, leave `fill_level` unchanged. The new entry goes to the tail.
- R9: From head word 3, the write burst is bits 31:24, the read burst is bits 23:16 and the sequence number is bits 15:0. A burst field of 0 is reported as 256; any other value is reported as itself. These appear on `hd_wr_burst`, `hd_rd_burst` and `hd_seq`.
- R10: From head word 4, the write stride is bits 31:16 and the read stride is bits 15:0. `hd_wr_fixed` or `hd_rd_fixed` is 1 when the corresponding stride is 0.
- R11: The head control word (word 7) is decoded as follows. `hd_chan` is bits 7:0 and `hd_err_mask` is bits 23:16. `hd_flags[7:0]` is bits 15:8, which are, from bit 8 up: start-of-packet, end-of-packet, park reads, park writes, end on end-of-packet, end on length, completion interrupt enable, early-end interrupt enable. `hd_flags[8]` is bit 24, early done.
- R12: `q_ready` while the FIFO is empty has no effect. `fill_level` stays 0 and `fifo_empty` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Descriptor word write strobe |
| wr_idx | input | 3 | Word index within the descriptor (7 = control) |
| wr_data | input | 32 | Word write data |
| fifo_full | output | 1 | FIFO holds DEPTH entries |
| fifo_empty | output | 1 | FIFO holds no entries |
| fill_level | output | 16 | Number of entries in the FIFO |
| overflow | output | 1 | Sticky: a go write was discarded |
| q_valid | output | 1 | Head descriptor available |
| q_ready | input | 1 | Engine accepts the head descriptor |
| q_desc | output | 256 | Head descriptor, word k at bits 32k+31:32k |
| hd_rd_burst | output | 9 | Read burst length, 1..256 |
| hd_wr_burst | output | 9 | Write burst length, 1..256 |
| hd_seq | output | 16 | Sequence number |
| hd_rd_stride | output | 16 | Read stride |
| hd_wr_stride | output | 16 | Write stride |
| hd_rd_fixed | output | 1 | Read address held constant |
| hd_wr_fixed | output | 1 | Write address held constant |
| hd_chan | output | 8 | Channel field |
| hd_flags | output | 9 | Control flags (see R11) |
| hd_err_mask | output | 8 | Error interrupt mask |

## Verification
The bench builds the block with DEPTH set to 4. This makes the full, overflow and wrap-around cases reachable within a few dozen writes, and three fill-and-drain rounds move the pointers past the end of the array several times. Descriptor contents come from a seed-based arithmetic formula. A few seeds are forced to zero bursts, zero strides or all-ones bursts so that the special decodings are covered. Every popped head is compared with the formula and with field slices taken from it.

// File: rtl/xdesc_pkg.sv
// Package: shared constants, decoded-head type and burst helper for the
// descriptor commit front end. Assumes 32-bit words and eight words per
// descriptor, with the control word last.
package xdesc_pkg;
    localparam int WORD_W   = 32;
    localparam int NWORDS   = 8;
    localparam int DESC_W   = WORD_W * NWORDS;
    localparam int IDX_W    = $clog2(NWORDS);
    localparam int CTRL_IDX = NWORDS - 1;
    localparam int GO_BIT   = 31;
    localparam int BURST_W  = 9;

    typedef struct packed {
        logic [BURST_W-1:0] rd_burst;
        logic [BURST_W-1:0] wr_burst;
        logic [15:0]        seq;
        logic [15:0]        rd_stride;
        logic [15:0]        wr_stride;
        logic               rd_fixed;
        logic               wr_fixed;
        logic [7:0]         chan;
        logic [8:0]         flags;
        logic [7:0]         err_mask;
    } hd_fields_t;

    // A raw burst of zero stands for the longest burst, 256 beats.
    function automatic logic [BURST_W-1:0] burst_len(input logic [7:0] raw);
        return (raw == 8'd0) ? BURST_W'(256) : {1'b0, raw};
    endfunction
endpackage

// File: rtl/xdesc_stage.sv
// Staging registers for descriptor words 0..NWORDS-2. Produces a one-cycle
// commit strobe and the full descriptor image when the control word is
// written with go set. Assumes one write per cycle, and that staged
// contents are never cleared by a commit.
module xdesc_stage
    import xdesc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    output logic              commit,
    output logic [DESC_W-1:0] commit_desc
);
    logic [WORD_W-1:0] stg [NWORDS-1];

    for (genvar k = 0; k < NWORDS - 1; k++) begin : g_word
        // Capture word k when it is addressed; otherwise hold it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                stg[k] <= '0;
            else if (wr_en && wr_idx == IDX_W'(k))
                stg[k] <= wr_data;
        end
        assign commit_desc[k*WORD_W +: WORD_W] = stg[k];
    end

    // The control slot comes directly from the bus, so the commit needs no extra cycle.
    assign commit_desc[CTRL_IDX*WORD_W +: WORD_W] = wr_data;

    // Commit strobe: a control word write with go set.
    assign commit = wr_en && (wr_idx == IDX_W'(CTRL_IDX)) && wr_data[GO_BIT];
endmodule

// File: rtl/xdesc_fifo.sv
// Descriptor FIFO with a valid/ready pop side, a fill level and a sticky
// overflow flag. A push while full is discarded. A push and a pop may
// happen in the same cycle. Assumes LVL_W can hold DEPTH.
module xdesc_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 256,
    parameter int LVL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [DW-1:0]    push_data,
    input  logic             pop_ready,
    output logic             valid,
    output logic [DW-1:0]    head,
    output logic             full,
    output logic             empty,
    output logic [LVL_W-1:0] level,
    output logic             overflow
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;
    logic          push_ok, pop_ok;

    assign full     = (cnt == CW'(DEPTH));
    assign empty    = (cnt == '0);
    assign valid    = !empty;
    assign push_ok  = push && !full;
    assign pop_ok   = valid && pop_ready;
    assign head     = mem[rd_ptr];
    assign level    = LVL_W'(cnt);

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Store an accepted entry at the tail.
    always_ff @(posedge clk) begin
        if (push_ok)
            mem[wr_ptr] <= push_data;
    end

    // Advance the pointers and the count for accepted pushes and pops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push_ok) wr_ptr <= nxt(wr_ptr);
            if (pop_ok)  rd_ptr <= nxt(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // Set the sticky flag on a discarded push; it clears only on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            overflow <= 1'b0;
        else if (push && full)
            overflow <= 1'b1;
    end

    // R6
    full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));
    // R6
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));
    // R3
    push_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full && !pop_ok) |=> level == $past(level) + 1'b1);
    // R5
    pop_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_ok && !push) |=> level == $past(level) - 1'b1);
    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop_ok) |=> $stable(level) && overflow);
    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
endmodule

// File: rtl/xdesc_decode.sv
// Combinational field decode of the head descriptor for the transfer
// engine. Assumes burst/sequence in word 3, strides in word 4 and
// control in word 7.
module xdesc_decode
    import xdesc_pkg::*;
(
    input  logic [DESC_W-1:0] desc,
    output hd_fields_t        fld
);
    logic [WORD_W-1:0] w_burst, w_stride, w_ctl;
    logic              unused_ctl_bits;

    assign w_burst  = desc[3*WORD_W +: WORD_W];
    assign w_stride = desc[4*WORD_W +: WORD_W];
    assign w_ctl    = desc[CTRL_IDX*WORD_W +: WORD_W];
    assign unused_ctl_bits = ^w_ctl[31:25];

    // Unpack every field of the head entry.
    always_comb begin
        fld.wr_burst  = burst_len(w_burst[31:24]);
        fld.rd_burst  = burst_len(w_burst[23:16]);
        fld.seq       = w_burst[15:0];
        fld.wr_stride = w_stride[31:16];
        fld.rd_stride = w_stride[15:0];
        fld.wr_fixed  = (w_stride[31:16] == 16'd0);
        fld.rd_fixed  = (w_stride[15:0] == 16'd0);
        fld.chan      = w_ctl[7:0];
        fld.flags     = {w_ctl[24], w_ctl[15:8]};
        fld.err_mask  = w_ctl[23:16];
    end
endmodule

// File: rtl/xdesc_commit.sv
// Top: descriptor staging, commit on go, FIFO and head decode.
// Assumes a single writer and a single consumer, both on clk.
module xdesc_commit
    import xdesc_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LVL_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [WORD_W-1:0]   wr_data,
    output logic                fifo_full,
    output logic                fifo_empty,
    output logic [LVL_W-1:0]    fill_level,
    output logic                overflow,
    output logic                q_valid,
    input  logic                q_ready,
    output logic [DESC_W-1:0]   q_desc,
    output logic [BURST_W-1:0]  hd_rd_burst,
    output logic [BURST_W-1:0]  hd_wr_burst,
    output logic [15:0]         hd_seq,
    output logic [15:0]         hd_rd_stride,
    output logic [15:0]         hd_wr_stride,
    output logic                hd_rd_fixed,
    output logic                hd_wr_fixed,
    output logic [7:0]          hd_chan,
    output logic [8:0]          hd_flags,
    output logic [7:0]          hd_err_mask
);
    logic              commit;
    logic [DESC_W-1:0] commit_desc;
    hd_fields_t        fld;

    xdesc_stage i_stage (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_data     (wr_data),
        .commit      (commit),
        .commit_desc (commit_desc)
    );

    xdesc_fifo #(.DEPTH(DEPTH), .DW(DESC_W), .LVL_W(LVL_W)) i_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (commit),
        .push_data (commit_desc),
        .pop_ready (q_ready),
        .valid     (q_valid),
        .head      (q_desc),
        .full      (fifo_full),
        .empty     (fifo_empty),
        .level     (fill_level),
        .overflow  (overflow)
    );

    xdesc_decode i_decode (
        .desc (q_desc),
        .fld  (fld)
    );

    assign hd_rd_burst  = fld.rd_burst;
    assign hd_wr_burst  = fld.wr_burst;
    assign hd_seq       = fld.seq;
    assign hd_rd_stride = fld.rd_stride;
    assign hd_wr_stride = fld.wr_stride;
    assign hd_rd_fixed  = fld.rd_fixed;
    assign hd_wr_fixed  = fld.wr_fixed;
    assign hd_chan      = fld.chan;
    assign hd_flags     = fld.flags;
    assign hd_err_mask  = fld.err_mask;

    // R2
    no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(wr_idx == IDX_W'(CTRL_IDX) && wr_data[GO_BIT]) && !(q_valid && q_ready))
        |=> fill_level == $past(fill_level));
    // R12
    idle_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_empty && q_ready && !wr_en) |=> fifo_empty);
    // R9
    burst_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_valid |-> (hd_rd_burst != '0) && (hd_wr_burst != '0));
    // R8
    swap_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IDX_W'(CTRL_IDX) && wr_data[GO_BIT] && q_valid && q_ready && !fifo_full)
        |=> fill_level == $past(fill_level));
endmodule

// File: tb/test_xdesc_commit.sv
module test_xdesc_commit;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_idx = '0;
    logic [31:0]  wr_data = '0;
    logic         q_ready = 1'b0;
    logic         fifo_full, fifo_empty, overflow, q_valid;
    logic [15:0]  fill_level;
    logic [255:0] q_desc;
    logic [8:0]   hd_rd_burst, hd_wr_burst, hd_flags;
    logic [15:0]  hd_seq, hd_rd_stride, hd_wr_stride;
    logic         hd_rd_fixed, hd_wr_fixed;
    logic [7:0]   hd_chan, hd_err_mask;

    int checks = 0;
    int errors = 0;
    int mq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    xdesc_commit #(.DEPTH(DEPTH)) i_xdesc_commit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty), .fill_level(fill_level),
        .overflow(overflow), .q_valid(q_valid), .q_ready(q_ready), .q_desc(q_desc),
        .hd_rd_burst(hd_rd_burst), .hd_wr_burst(hd_wr_burst), .hd_seq(hd_seq),
        .hd_rd_stride(hd_rd_stride), .hd_wr_stride(hd_wr_stride),
        .hd_rd_fixed(hd_rd_fixed), .hd_wr_fixed(hd_wr_fixed), .hd_chan(hd_chan),
        .hd_flags(hd_flags), .hd_err_mask(hd_err_mask)
    );

    task automatic check(string req, logic [255:0] act, logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Word k of the descriptor built from seed s (control word has go set).
    function automatic logic [31:0] mkw(int s, int k);
        logic [31:0] w;
        w = 32'(s) * 32'h0100_0193 + 32'(k) * 32'h9E37_79B1 + 32'h0000_1357;
        if (k == 3 && s == 0) w = 32'h0000_BEEF;
        if (k == 3 && s == 2) w = 32'hFFFF_0001;
        if (k == 4 && s == 1) w = 32'h0000_0000;
        if (k == 4 && s == 2) w = 32'h0001_0000;
        if (k == 7) w[31] = 1'b1;
        return w;
    endfunction

    function automatic logic [255:0] mkd(int s);
        logic [255:0] d;
        for (int k = 0; k < 8; k++) d[k*32 +: 32] = mkw(s, k);
        return d;
    endfunction

    function automatic logic [8:0] blen(logic [7:0] r);
        return (r == 0) ? 9'd256 : {1'b0, r};
    endfunction

    task automatic wr(int idx, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'(idx); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load(int s);
        for (int k = 0; k < 8; k++) wr(k, mkw(s, k));
    endtask

    task automatic pop();
        @(negedge clk);
        q_ready = 1'b1;
        @(negedge clk);
        q_ready = 1'b0;
    endtask

    // Compare the head entry and its decoded fields with seed s.
    task automatic check_head(int s);
        logic [31:0] w3, w4, w7;
        w3 = mkw(s, 3); w4 = mkw(s, 4); w7 = mkw(s, 7);
        check("R5 head order", q_desc, mkd(s));
        check("R9 wr burst", 256'(hd_wr_burst), 256'(blen(w3[31:24])));
        check("R9 rd burst", 256'(hd_rd_burst), 256'(blen(w3[23:16])));
        check("R9 seq", 256'(hd_seq), 256'(w3[15:0]));
        check("R10 strides", 256'({hd_wr_stride, hd_rd_stride}), 256'(w4));
        check("R10 fixed", 256'({hd_wr_fixed, hd_rd_fixed}),
              256'({w4[31:16] == 0, w4[15:0] == 0}));
        check("R11 chan", 256'(hd_chan), 256'(w7[7:0]));
        check("R11 flags", 256'(hd_flags), 256'({w7[24], w7[15:8]}));
        check("R11 err mask", 256'(hd_err_mask), 256'(w7[23:16]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [255:0] e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 empty", 256'(fifo_empty), 256'(1));
        check("R1 full", 256'(fifo_full), 256'(0));
        check("R1 level", 256'(fill_level), 256'(0));
        check("R1 overflow", 256'(overflow), 256'(0));
        check("R1 valid", 256'(q_valid), 256'(0));

        // R12 pop on empty has no effect
        pop();
        check("R12 level", 256'(fill_level), 256'(0));
        check("R12 empty", 256'(fifo_empty), 256'(1));

        // R2 staging writes and go-less control commit nothing
        for (int k = 0; k < 7; k++) begin
            wr(k, mkw(5, k));
            check("R2 level", 256'(fill_level), 256'(0));
        end
        wr(7, mkw(5, 7) & 32'h7FFF_FFFF);
        check("R2 no go", 256'(fill_level), 256'(0));

        // R3 commit with go
        wr(7, mkw(5, 7));
        check("R3 level", 256'(fill_level), 256'(1));
        check("R3 valid", 256'(q_valid), 256'(1));
        check("R3 packing", q_desc, mkd(5));

        // R4 staged words persist: recommit with only a new control word
        wr(7, 32'h8000_00A5);
        check("R4 level", 256'(fill_level), 256'(2));
        pop();
        check("R5 level after pop", 256'(fill_level), 256'(1));
        e = mkd(5); e[255:224] = 32'h8000_00A5;
        check("R4 persist", q_desc, e);
        pop();
        check("R6 empty", 256'(fifo_empty), 256'(1));

        // Fill, overflow and drain sweeps; pointers wrap
        for (int r = 0; r < 3; r++) begin
            for (int i = 0; i < DEPTH; i++) begin
                load(r * DEPTH + i);
                mq.push_back(r * DEPTH + i);
                check("R3 fill level", 256'(fill_level), 256'(i + 1));
                check("R6 full flag", 256'(fifo_full), 256'(i + 1 == DEPTH));
            end
            load(99);
            check("R7 level kept", 256'(fill_level), 256'(DEPTH));
            check("R7 overflow set", 256'(overflow), 256'(1));
            for (int i = 0; i < DEPTH; i++) begin
                check_head(mq.pop_front());
                pop();
                check("R5 drain level", 256'(fill_level), 256'(DEPTH - 1 - i));
            end
            check("R6 empty after drain", 256'(fifo_empty), 256'(1));
            check("R7 sticky", 256'(overflow), 256'(1));
        end

        // R8 simultaneous commit and pop
        load(20);
        load(21);
        for (int k = 0; k < 7; k++) wr(k, mkw(22, k));
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'd7; wr_data = mkw(22, 7); q_ready = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; q_ready = 1'b0;
        check("R8 level", 256'(fill_level), 256'(2));
        check_head(21);
        pop();
        check_head(22);
        pop();
        check("R8 drained", 256'(fifo_empty), 256'(1));

        // R7 overflow clears only on reset
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R7 cleared by reset", 256'(overflow), 256'(0));
        check("R1 level after reset", 256'(fill_level), 256'(0));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule